// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. A receive-time enable pulse, supplied from outside at sixteen times the bit rate, paces all sampling. The block first passes the line through a two-flop synchronizer. While idle, it looks for a genuine falling edge. It then takes the value of every bit from a vote among three samples near the middle of the bit.

Each frame is one start bit, eight data bits sent least significant first, and one stop bit. When the stop bit has been sampled, the received byte and its status are moved into an output holding stage:

- a full flag,
- a noise flag for any split vote,
- a framing error for a low stop bit,
- a break indication for an all-zero frame.

The flags stay set until the clear strobe. A frame that completes while the holding stage is still full raises an overrun flag instead of overwriting the byte. The bit clock, parity and the transmit side are generated elsewhere.

Top module: `serial_rx_os`

## Requirements
- R1: A low sample opens a frame only when the three samples just before it were all high. A low that lacks this history is not a start bit, and if no qualified edge follows, no frame completes.
- R2: Each bit takes the majority value of its samples 8, 9 and 10, counted from 1 at the first sample of that bit. The edge sample is sample 1 of the start bit.
- R3: A high sample at position 3, 5 or 7 of the start bit, or a start-bit vote of 1, abandons the frame. Edge search then starts again, and the abandoned attempt leaves no trace in the outputs.
- R4: If the three mid-bit samples of any bit do not all agree, `noise_flag` is set with the frame. Reception continues and the byte still completes.
- R5: A stop bit that votes 0 sets `frame_err`. The byte is still delivered.
- R6: A frame whose start, data and stop bits all vote 0 sets `break_det` and `frame_err`, with `rx_data` equal to 0. The receiver searches again only after the line has returned high.
- R7: `frame_err` and `break_det` become visible in the same clock cycle as `rx_full`.
- R8: The first data bit after the start bit lands in `rx_data[0]` and the last in `rx_data[7]`.
- R9: `rx_full`, `noise_flag`, `frame_err`, `break_det`, `overrun_flag` and `rx_data` hold their values until `clr_stb`. `clr_stb` clears all five flags.
- R10: A frame that completes while `rx_full` is set raises `overrun_flag`. Its byte and its status are discarded.
- R11: After reset, all flags are 0, `rx_data` is 0, and the receiver is searching for an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| clr_stb | input | 1 | Clears the holding stage flags |
| rx_data | output | 8 | Last accepted byte |
| rx_full | output | 1 | Holding stage has an unread byte |
| noise_flag | output | 1 | Split mid-bit vote seen in held frame |
| frame_err | output | 1 | Held frame had a low stop bit |
| break_det | output | 1 | Held frame was all zero |
| overrun_flag | output | 1 | A frame was lost while full |

## Verification
The bench builds the block with its defaults: eight data bits and sixteen samples per bit. The eight-bit width keeps every byte value in reach, so all 256 values are swept through clean frames and the result is compared with the value sent. One sample period is one bench slot. Because of this, noise can be placed on exactly sample 3, 7, 8, 9 or 10 of a chosen bit, and the early-abort, vote and edge-history rules can each be driven to their boundary.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE    = 2'd0,
    RX_FRAME   = 2'd1,
    RX_BRKWAIT = 2'd2
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote (
  input  logic s_a,
  input  logic s_b,
  input  logic s_c,
  output logic value,
  output logic split
);
  assign value = (s_a & s_b) | (s_a & s_c) | (s_b & s_c);
  assign split = (s_a ^ s_b) | (s_b ^ s_c);
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  output logic                 commit,
  output logic [DATA_BITS-1:0] frm_data,
  output logic                 frm_noise,
  output logic                 frm_stop_bad,
  output logic                 frm_break
);
  localparam int CW = $clog2(OSR + 1);
  localparam int NB = DATA_BITS + 2;
  localparam int IW = $clog2(NB);
  localparam logic [CW-1:0] P_E1  = CW'(3);
  localparam logic [CW-1:0] P_E2  = CW'(5);
  localparam logic [CW-1:0] P_E3  = CW'(7);
  localparam logic [CW-1:0] P_V1  = CW'(OSR / 2);
  localparam logic [CW-1:0] P_V2  = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] P_V3  = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] P_END = CW'(OSR);
  localparam logic [IW-1:0] STOP_IDX = IW'(DATA_BITS + 1);

  rx_state_e            state_q, state_n;
  logic [CW-1:0]        cnt_q, cnt_n, rt;
  logic [IW-1:0]        idx_q, idx_n;
  logic [2:0]           hist_q, hist_n;
  logic                 v1_q, v1_n, v2_q, v2_n;
  logic [DATA_BITS-1:0] sh_q, sh_n;
  logic                 noise_q, noise_n, zero_q, zero_n;
  logic                 vote_val, vote_split;

  serial_rx_vote u_vote (
    .s_a   (v1_q),
    .s_b   (v2_q),
    .s_c   (line),
    .value (vote_val),
    .split (vote_split)
  );

  assign rt = cnt_q + 1'b1;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    hist_n  = hist_q;
    v1_n    = v1_q;
    v2_n    = v2_q;
    sh_n    = sh_q;
    noise_n = noise_q;
    zero_n  = zero_q;
    commit  = 1'b0;
    if (tick) begin
      hist_n = {hist_q[1:0], line};
      unique case (state_q)
        RX_IDLE: begin
          if (!line && hist_q == 3'b111) begin
            state_n = RX_FRAME;
            cnt_n   = CW'(1);
            idx_n   = '0;
            noise_n = 1'b0;
            zero_n  = 1'b1;
          end
        end
        RX_FRAME: begin
          cnt_n = rt;
          if (idx_q == '0 && line && (rt == P_E1 || rt == P_E2 || rt == P_E3)) begin
            state_n = RX_IDLE;
          end else begin
            if (rt == P_V1) v1_n = line;
            if (rt == P_V2) v2_n = line;
            if (rt == P_V3) begin
              noise_n = noise_q | vote_split;
              zero_n  = zero_q & ~vote_val;
              if (idx_q == '0) begin
                if (vote_val) state_n = RX_IDLE;
              end else if (idx_q == STOP_IDX) begin
                commit  = 1'b1;
                state_n = (zero_q & ~vote_val) ? RX_BRKWAIT : RX_IDLE;
              end else begin
                sh_n = {vote_val, sh_q[DATA_BITS-1:1]};
              end
            end
            if (rt == P_END) begin
              cnt_n = '0;
              idx_n = idx_q + 1'b1;
            end
          end
        end
        RX_BRKWAIT: begin
          if (line) state_n = RX_IDLE;
        end
        default: state_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      hist_q  <= '0;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      sh_q    <= '0;
      noise_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      hist_q  <= hist_n;
      v1_q    <= v1_n;
      v2_q    <= v2_n;
      sh_q    <= sh_n;
      noise_q <= noise_n;
      zero_q  <= zero_n;
    end
  end

  assign frm_data     = sh_q;
  assign frm_noise    = noise_q | vote_split;
  assign frm_stop_bad = ~vote_val;
  assign frm_break    = zero_q & ~vote_val;
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 commit,
  input  logic [DATA_BITS-1:0] in_data,
  input  logic                 in_noise,
  input  logic                 in_stop_bad,
  input  logic                 in_break,
  output logic [DATA_BITS-1:0] data_q,
  output logic                 full_q,
  output logic                 nf_q,
  output logic                 fe_q,
  output logic                 brk_q,
  output logic                 ovr_q
);
  logic [DATA_BITS-1:0] data_n;
  logic full_n, nf_n, fe_n, brk_n, ovr_n;

  always_comb begin
    data_n = data_q;
    full_n = full_q;
    nf_n   = nf_q;
    fe_n   = fe_q;
    brk_n  = brk_q;
    ovr_n  = ovr_q;
    if (clr) begin
      full_n = 1'b0;
      nf_n   = 1'b0;
      fe_n   = 1'b0;
      brk_n  = 1'b0;
      ovr_n  = 1'b0;
    end
    if (commit) begin
      if (full_n) begin
        ovr_n = 1'b1;
      end else begin
        data_n = in_data;
        full_n = 1'b1;
        nf_n   = in_noise;
        fe_n   = in_stop_bad;
        brk_n  = in_break;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      nf_q   <= 1'b0;
      fe_q   <= 1'b0;
      brk_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      full_q <= full_n;
      nf_q   <= nf_n;
      fe_q   <= fe_n;
      brk_q  <= brk_n;
      ovr_q  <= ovr_n;
    end
  end
endmodule

// File: rtl/serial_rx_os.sv
module serial_rx_os #(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rt_tick,
  input  logic                 rxd,
  input  logic                 clr_stb,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_full,
  output logic                 noise_flag,
  output logic                 frame_err,
  output logic                 break_det,
  output logic                 overrun_flag
);
  logic [1:0]           rst_pipe;
  logic                 rst_core_n;
  logic                 line_s;
  logic                 frm_commit;
  logic [DATA_BITS-1:0] frm_data;
  logic                 frm_noise, frm_stop_bad, frm_break;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (rxd),
    .dout  (line_s)
  );

  serial_rx_engine #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_engine (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .tick         (rt_tick),
    .line         (line_s),
    .commit       (frm_commit),
    .frm_data     (frm_data),
    .frm_noise    (frm_noise),
    .frm_stop_bad (frm_stop_bad),
    .frm_break    (frm_break)
  );

  serial_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .clr         (clr_stb),
    .commit      (frm_commit),
    .in_data     (frm_data),
    .in_noise    (frm_noise),
    .in_stop_bad (frm_stop_bad),
    .in_break    (frm_break),
    .data_q      (rx_data),
    .full_q      (rx_full),
    .nf_q        (noise_flag),
    .fe_q        (frame_err),
    .brk_q       (break_det),
    .ovr_q       (overrun_flag)
  );
endmodule

// File: rtl/serial_rx_os_chk.sv
module serial_rx_os_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_stb,
  input logic                 frm_commit,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_full,
  input logic                 noise_flag,
  input logic                 frame_err,
  input logic                 break_det,
  input logic                 overrun_flag
);
  assert_fe_with_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> (rx_full && $past(frm_commit)));

  assert_break_is_fe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |-> frame_err);

  assert_full_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !clr_stb) |=> rx_full);

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !frm_commit) |=> !(rx_full || noise_flag || frame_err || break_det || overrun_flag));

  assert_keep_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !clr_stb) |=> $stable(rx_data));

  assert_overrun_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_flag) |-> $past(rx_full));
endmodule

bind serial_rx_os serial_rx_os_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_stb      (clr_stb),
  .frm_commit   (frm_commit),
  .rx_data      (rx_data),
  .rx_full      (rx_full),
  .noise_flag   (noise_flag),
  .frame_err    (frame_err),
  .break_det    (break_det),
  .overrun_flag (overrun_flag)
);

// File: tb/serial_rx_os_bench.sv
module serial_rx_os_bench;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rst_n, rt_tick, rxd, clr_stb;
  logic [DB-1:0] rx_data;
  logic rx_full, noise_flag, frame_err, break_det, overrun_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_rx_os u_serial_rx_os (
    .clk          (clk),
    .rst_n        (rst_n),
    .rt_tick      (rt_tick),
    .rxd          (rxd),
    .clr_stb      (clr_stb),
    .rx_data      (rx_data),
    .rx_full      (rx_full),
    .noise_flag   (noise_flag),
    .frame_err    (frame_err),
    .break_det    (break_det),
    .overrun_flag (overrun_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one sample period: line value settles through the synchronizer before the tick
  task automatic slot(input logic v);
    @(negedge clk); rxd = v; rt_tick = 1'b0;
    @(negedge clk);
    @(negedge clk); rt_tick = 1'b1;
  endtask

  task automatic tick_off();
    @(negedge clk); rt_tick = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); rt_tick = 1'b0; clr_stb = 1'b1;
    @(negedge clk); clr_stb = 1'b0;
  endtask

  // bit index 0 start, 1..8 data, 9 stop; flip samples fa and fb (1-based) of bit nb
  task automatic send_frame(input logic [7:0] d, input logic stop_v,
                            input int nb, input int fa, input int fb);
    for (int i = 0; i < 4; i++) slot(1'b1);
    for (int b = 0; b < 10; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
      for (int r = 1; r <= 16; r++) begin
        logic s;
        s = v;
        if (b == nb && (r == fa || r == fb)) s = ~v;
        slot(s);
      end
    end
    slot(1'b1);
    tick_off();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rt_tick = 1'b0; rxd = 1'b1; clr_stb = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk("R11 data", rx_data, 0);
    chk("R11 full", rx_full, 0);
    chk("R11 nf", noise_flag, 0);
    chk("R11 fe", frame_err, 0);
    chk("R11 brk", break_det, 0);
    chk("R11 ovr", overrun_flag, 0);

    // R8 / R2 sweep of every byte value, clean frames
    for (int v = 0; v < 256; v++) begin
      send_frame(v[7:0], 1'b1, -1, 0, 0);
      chk("R8 data lsb first", rx_data, v);
      chk("R2 full", rx_full, 1);
      chk("R4 clean nf", noise_flag, 0);
      chk("R5 clean fe", frame_err, 0);
      clear();
    end

    // R4 single split sample in data bit 2 (bit index 3)
    send_frame(8'hA5, 1'b1, 3, 9, 0);
    chk("R4 data kept", rx_data, 8'hA5);
    chk("R4 nf", noise_flag, 1);
    chk("R4 fe", frame_err, 0);
    clear();

    // R4 split sample in start bit still receives
    send_frame(8'h3E, 1'b1, 0, 9, 0);
    chk("R4 start split data", rx_data, 8'h3E);
    chk("R4 start split nf", noise_flag, 1);
    clear();

    // R2 two of three samples flipped flips the bit
    send_frame(8'hA5, 1'b1, 4, 8, 9);
    chk("R2 majority data", rx_data, 8'hAD);
    chk("R2 majority nf", noise_flag, 1);
    clear();

    // R2 samples outside 8..10 do not count
    send_frame(8'hA5, 1'b1, 2, 7, 11);
    chk("R2 outside window data", rx_data, 8'hA5);
    chk("R2 outside window nf", noise_flag, 0);
    clear();

    // R5 / R7 low stop bit
    send_frame(8'h5A, 1'b0, -1, 0, 0);
    chk("R7 full with fe", rx_full, 1);
    chk("R5 fe", frame_err, 1);
    chk("R5 data", rx_data, 8'h5A);
    chk("R6 no break", break_det, 0);
    clear();

    // R6 break: all low plus extra low time
    for (int i = 0; i < 4; i++) slot(1'b1);
    for (int i = 0; i < 180; i++) slot(1'b0);
    tick_off();
    chk("R6 brk", break_det, 1);
    chk("R6 fe", frame_err, 1);
    chk("R6 data", rx_data, 0);
    chk("R7 brk full", rx_full, 1);
    clear();
    send_frame(8'h3C, 1'b1, -1, 0, 0);
    chk("R6 after break data", rx_data, 8'h3C);
    chk("R6 after break brk", break_det, 0);
    clear();

    // R3 high at sample 3 of start bit
    for (int i = 0; i < 4; i++) slot(1'b1);
    slot(1'b0); slot(1'b0); slot(1'b1);
    tick_off();
    chk("R3 rt3 no frame", rx_full, 0);
    send_frame(8'h96, 1'b1, -1, 0, 0);
    chk("R3 rt3 restart data", rx_data, 8'h96);
    chk("R3 rt3 restart nf", noise_flag, 0);
    clear();

    // R3 high at sample 7 of start bit
    for (int i = 0; i < 4; i++) slot(1'b1);
    for (int i = 0; i < 6; i++) slot(1'b0);
    slot(1'b1);
    tick_off();
    chk("R3 rt7 no frame", rx_full, 0);
    send_frame(8'h69, 1'b1, -1, 0, 0);
    chk("R3 rt7 restart data", rx_data, 8'h69);
    chk("R3 rt7 restart nf", noise_flag, 0);
    clear();

    // R1 low without three prior highs is ignored
    for (int i = 0; i < 4; i++) slot(1'b1);
    slot(1'b0); slot(1'b1); slot(1'b1);
    for (int i = 0; i < 144; i++) slot(1'b0);
    for (int i = 0; i < 20; i++) slot(1'b1);
    tick_off();
    chk("R1 unqualified low", rx_full, 0);
    chk("R1 unqualified fe", frame_err, 0);

    // R9 sticky until clear
    send_frame(8'h11, 1'b1, 1, 10, 0);
    for (int i = 0; i < 30; i++) slot(1'b1);
    tick_off();
    chk("R9 full held", rx_full, 1);
    chk("R9 data held", rx_data, 8'h11);
    chk("R9 nf held", noise_flag, 1);
    clear();
    chk("R9 full cleared", rx_full, 0);
    chk("R9 nf cleared", noise_flag, 0);

    // R10 overrun
    send_frame(8'h22, 1'b1, -1, 0, 0);
    send_frame(8'h33, 1'b0, -1, 0, 0);
    chk("R10 ovr", overrun_flag, 1);
    chk("R10 data kept", rx_data, 8'h22);
    chk("R10 fe not taken", frame_err, 0);
    chk("R10 full", rx_full, 1);
    clear();
    chk("R10 ovr cleared", overrun_flag, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule